// File: doc/BRIEF.md
# Serial Receive Path Selector

This block sits in front of a 1:16 deserializer on the serial receive side. Each bit-clock cycle it picks the bit the deserializer sees. That bit is either the line bit or the bit looped back from the local transmitter. The line bit is squelched to zero whenever the optical signal-detect input reports loss of light, but the squelch does not apply while diagnostic loopback is selected. The block registers the chosen bit once before handing it on.

From the serial clock it derives a divide-by-16 word counter. The counter drives three outputs: a one-cycle word strobe for the downstream holding register, a free-running word clock, and a parallel output clock in the opposite phase. A kill input forces both derived clocks low. Reset also holds them low. Whenever the source selection changes, the counter restarts so that no partial word is ever strobed out.

A separate line-loopback path gives a retimed copy of the raw line bit and a gated copy of the serial clock. Both are driven to zero unless line loopback is enabled. `clk_i` is the serial bit clock of whichever source is selected.

Top module: `rx_path_sel`

## Requirements
- R1: With `diag_lb_n_i` high, `ser_bit_o` one clock after a sampling edge equals the line bit sampled there (when `sig_det_i` is high). With `diag_lb_n_i` low, it equals the loopback bit sampled there.
- R2: With `diag_lb_n_i` high and `sig_det_i` low, `ser_bit_o` is 0 one clock later, whatever the line bit.
- R3: With `diag_lb_n_i` low, `sig_det_i` has no effect on `ser_bit_o`.
- R4: The word counter advances by one each clock and wraps modulo 16. It holds count 0 while reset is asserted. `word_clk_o` is high exactly when the count is 8..15. `par_clk_o` is high exactly when the count is 0..7 and reset is released. Each has a period of 16 clocks.
- R5: `word_stb_o` is high for exactly the one clock in which the count is 15. The first strobe comes 15 edges after reset is released.
- R6: While `clk_kill_n_i` is low, `word_clk_o` and `par_clk_o` are both 0. The counter keeps running, so the clocks resume in their normal phase when the kill input is released.
- R7: While `rst_n_i` is low, `word_clk_o`, `par_clk_o`, `word_stb_o`, `ser_bit_o` and `lb_bit_o` are all 0.
- R8: With `line_lb_n_i` low, `lb_bit_o` equals the raw (unsquelched) line bit from one clock earlier, and `lb_clk_o` follows `clk_i`.
- R9: With `line_lb_n_i` high, `lb_bit_o` is 0 one clock later and `lb_clk_o` is 0.
- R10: At an edge where the sampled `diag_lb_n_i` differs from the current source, the count returns to 0. The next strobe therefore comes 15 edges after the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Serial bit clock of the selected source |
| rst_n_i | input | 1 | Asynchronous reset, active low |
| line_bit_i | input | 1 | Line serial data bit |
| loop_bit_i | input | 1 | Diagnostic loopback data bit from the local transmitter |
| sig_det_i | input | 1 | Optical signal present, active high |
| diag_lb_n_i | input | 1 | Diagnostic loopback select, active low |
| line_lb_n_i | input | 1 | Line loopback enable, active low |
| clk_kill_n_i | input | 1 | Derived clock enable; low forces the derived clocks to 0 |
| ser_bit_o | output | 1 | Registered, selected and squelched bit to the deserializer |
| word_stb_o | output | 1 | One-cycle word strobe at count 15 |
| word_clk_o | output | 1 | Free-running divide-by-16 word clock |
| par_clk_o | output | 1 | Parallel output clock, opposite phase to the word clock |
| lb_bit_o | output | 1 | Retimed line-loopback data |
| lb_clk_o | output | 1 | Gated copy of the serial clock for line loopback |

## Verification
The hardest case to reach is a source switch in the middle of a word, where the counter must drop its partial count and restart. The stimulus lets the counter run to a count well away from 0 and 15, then flips `diag_lb_n_i`. It then confirms that the strobe waits a full 15 edges and that the derived clocks restart from their count-0 phase. A second awkward case combines loss of signal with diagnostic loopback. For this, `sig_det_i` is held low across both source choices, so the bench can show that the squelch follows the selection.

// File: rtl/rxsel_pkg.sv
package rxsel_pkg;

    typedef enum logic {
        SRC_LINE = 1'b0,
        SRC_LOOP = 1'b1
    } src_e;

endpackage

// File: rtl/rx_src_mux.sv
module rx_src_mux
    import rxsel_pkg::*;
(
    input  logic clk_i,
    input  logic rst_n_i,
    input  src_e src_i,
    input  logic line_bit_i,
    input  logic loop_bit_i,
    input  logic sig_det_i,
    output logic ser_bit_o
);

    typedef struct packed {
        logic bit_v;
    } mux_st_t;

    mux_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_i == SRC_LOOP) begin
            st_d.bit_v = loop_bit_i;
        end else begin
            st_d.bit_v = line_bit_i & sig_det_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ser_bit_o = st_q.bit_v;

    AST_SQUELCH_LINE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (src_i == SRC_LINE && !sig_det_i) |=> !ser_bit_o); // R2

    AST_LOOP_PASS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (src_i == SRC_LOOP) |=> (ser_bit_o == $past(loop_bit_i))); // R3

endmodule

// File: rtl/rx_word_div.sv
module rx_word_div
    import rxsel_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  src_e src_i,
    output logic stb_o,
    output logic wclk_o,
    output logic pclk_o
);

    localparam int unsigned CW = DIV_LOG2;
    localparam logic [CW-1:0] LAST = {CW{1'b1}};

    typedef struct packed {
        logic [CW-1:0] cnt;
        src_e          src;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (src_i != st_q.src) begin
            st_d.cnt = '0;
            st_d.src = src_i;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q.cnt <= '0;
            st_q.src <= SRC_LINE;
        end else begin
            st_q <= st_d;
        end
    end

    assign stb_o  = (st_q.cnt == LAST);
    assign wclk_o = st_q.cnt[CW-1];
    assign pclk_o = ~st_q.cnt[CW-1];

    AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        stb_o |=> !stb_o); // R5

    AST_SWITCH_NO_STROBE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (src_i != st_q.src) |=> !stb_o); // R10

endmodule

// File: rtl/rx_line_lpbk.sv
module rx_line_lpbk (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic en_i,
    input  logic line_bit_i,
    output logic lb_bit_o,
    output logic lb_clk_o
);

    typedef struct packed {
        logic bit_v;
    } lb_st_t;

    lb_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.bit_v = en_i & line_bit_i;
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lb_bit_o = st_q.bit_v;
    assign lb_clk_o = clk_i & en_i;

    AST_LB_RETIME: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        en_i |=> (lb_bit_o == $past(line_bit_i))); // R8

    AST_LB_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        !en_i |=> !lb_bit_o); // R9

endmodule

// File: rtl/rx_path_sel.sv
module rx_path_sel
    import rxsel_pkg::*;
#(
    parameter int unsigned DIV_LOG2 = 4
) (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic line_bit_i,
    input  logic loop_bit_i,
    input  logic sig_det_i,
    input  logic diag_lb_n_i,
    input  logic line_lb_n_i,
    input  logic clk_kill_n_i,
    output logic ser_bit_o,
    output logic word_stb_o,
    output logic word_clk_o,
    output logic par_clk_o,
    output logic lb_bit_o,
    output logic lb_clk_o
);

    src_e src;
    logic wclk_raw;
    logic pclk_raw;

    assign src = diag_lb_n_i ? SRC_LINE : SRC_LOOP;

    rx_src_mux u_mux (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .src_i      (src),
        .line_bit_i (line_bit_i),
        .loop_bit_i (loop_bit_i),
        .sig_det_i  (sig_det_i),
        .ser_bit_o  (ser_bit_o)
    );

    rx_word_div #(.DIV_LOG2(DIV_LOG2)) u_div (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_i),
        .src_i   (src),
        .stb_o   (word_stb_o),
        .wclk_o  (wclk_raw),
        .pclk_o  (pclk_raw)
    );

    rx_line_lpbk u_lpbk (
        .clk_i      (clk_i),
        .rst_n_i    (rst_n_i),
        .en_i       (~line_lb_n_i),
        .line_bit_i (line_bit_i),
        .lb_bit_o   (lb_bit_o),
        .lb_clk_o   (lb_clk_o)
    );

    assign word_clk_o = wclk_raw & clk_kill_n_i;
    assign par_clk_o  = pclk_raw & clk_kill_n_i & rst_n_i;

    AST_LINE_PASS: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        (diag_lb_n_i && sig_det_i) |=> (ser_bit_o == $past(line_bit_i))); // R1

    AST_CLK_PHASE: assert property (@(posedge clk_i) disable iff (!rst_n_i)
        clk_kill_n_i |-> (word_clk_o != par_clk_o)); // R4

endmodule

// File: tb/rx_path_sel_bench.sv
module rx_path_sel_bench;

    localparam int PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_bit = 1'b0;
    logic loop_bit = 1'b0;
    logic sd = 1'b1;
    logic dlb_n = 1'b1;
    logic llb_n = 1'b1;
    logic kill_n = 1'b1;
    logic ser_bit, stb, wclk, pclk, lb_bit, lb_clk;

    int checks = 0;
    int errors = 0;
    logic [3:0] mcnt = '0;
    logic mprev = 1'b1;

    always #(PERIOD/2) clk = ~clk;

    rx_path_sel u_rx_path_sel (
        .clk_i        (clk),
        .rst_n_i      (rst_n),
        .line_bit_i   (line_bit),
        .loop_bit_i   (loop_bit),
        .sig_det_i    (sd),
        .diag_lb_n_i  (dlb_n),
        .line_lb_n_i  (llb_n),
        .clk_kill_n_i (kill_n),
        .ser_bit_o    (ser_bit),
        .word_stb_o   (stb),
        .word_clk_o   (wclk),
        .par_clk_o    (pclk),
        .lb_bit_o     (lb_bit),
        .lb_clk_o     (lb_clk)
    );

    task automatic chk(input string req, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        if (!rst_n) begin
            mcnt = '0;
            mprev = 1'b1;
        end else if (dlb_n != mprev) begin
            mcnt = '0;
            mprev = dlb_n;
        end else begin
            mcnt = mcnt + 1'b1;
        end
        #1;
    endtask

    task automatic chk_div(input string req);
        chk(req, "word_stb", stb, mcnt == 4'd15);
        chk(req, "word_clk", wclk, kill_n & mcnt[3]);
        chk(req, "par_clk", pclk, kill_n & rst_n & ~mcnt[3]);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mcnt = '0;
        mprev = 1'b1;
        line_bit = 1'b1;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R7", "word_clk in reset", wclk, 1'b0);
            chk("R7", "par_clk in reset", pclk, 1'b0);
            chk("R7", "strobe in reset", stb, 1'b0);
            chk("R7", "ser_bit in reset", ser_bit, 1'b0);
            chk("R7", "lb_bit in reset", lb_bit, 1'b0);
        end
        rst_n = 1'b1;
    endtask

    task automatic t_divider();
        int first = -1;
        for (int i = 1; i <= 40; i++) begin
            step();
            chk_div("R4");
            if (stb && first < 0) first = i;
        end
        checks++;
        if (first != 15) begin
            errors++;
            $display("FAIL R5 first strobe edge actual=%0d expected=15", first);
        end
    endtask

    task automatic t_line_select();
        logic exp;
        dlb_n = 1'b1;
        sd = 1'b1;
        for (int i = 0; i < 12; i++) begin
            line_bit = i[0] ^ i[2];
            loop_bit = ~line_bit;
            exp = line_bit;
            step();
            chk("R1", "line select", ser_bit, exp);
        end
    endtask

    task automatic t_squelch();
        dlb_n = 1'b1;
        sd = 1'b0;
        for (int i = 0; i < 6; i++) begin
            line_bit = 1'b1;
            loop_bit = 1'b1;
            step();
            chk("R2", "squelched line", ser_bit, 1'b0);
        end
        sd = 1'b1;
    endtask

    task automatic t_loop_switch();
        logic exp;
        int seen = -1;
        dlb_n = 1'b1;
        while (mcnt != 4'd6) step();
        dlb_n = 1'b0;
        sd = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            loop_bit = i[0] ^ i[1];
            line_bit = 1'b0;
            sd = i[2];
            exp = loop_bit;
            step();
            chk("R3", "loop bit despite sig_det", ser_bit, exp);
            chk_div("R10");
            if (stb && seen < 0) seen = i;
        end
        checks++;
        if (seen != 16) begin
            errors++;
            $display("FAIL R10 strobe edge after switch actual=%0d expected=16", seen);
        end
        dlb_n = 1'b1;
        sd = 1'b1;
        step();
        chk("R10", "count restart on return", wclk, 1'b0);
        chk("R10", "par clk restart on return", pclk, 1'b1);
    endtask

    task automatic t_kill();
        kill_n = 1'b0;
        #1;
        chk("R6", "word_clk killed", wclk, 1'b0);
        chk("R6", "par_clk killed", pclk, 1'b0);
        for (int i = 0; i < 20; i++) begin
            step();
            chk("R6", "word_clk killed", wclk, 1'b0);
            chk("R6", "par_clk killed", pclk, 1'b0);
        end
        kill_n = 1'b1;
        for (int i = 0; i < 18; i++) begin
            step();
            chk_div("R6");
        end
    endtask

    task automatic t_line_loop();
        logic exp;
        llb_n = 1'b0;
        sd = 1'b0;
        for (int i = 0; i < 10; i++) begin
            line_bit = i[0] | i[3];
            exp = line_bit;
            step();
            chk("R8", "lb_bit retimed", lb_bit, exp);
            chk("R8", "lb_clk high phase", lb_clk, 1'b1);
            @(negedge clk);
            #1;
            chk("R8", "lb_clk low phase", lb_clk, 1'b0);
        end
        llb_n = 1'b1;
        for (int i = 0; i < 6; i++) begin
            line_bit = 1'b1;
            step();
            chk("R9", "lb_bit quiet", lb_bit, 1'b0);
            chk("R9", "lb_clk quiet", lb_clk, 1'b0);
        end
        sd = 1'b1;
    endtask

    initial begin
        #(PERIOD * 200000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2;
        t_reset();
        t_divider();
        t_line_select();
        t_squelch();
        t_loop_switch();
        t_kill();
        t_line_loop();
        t_reset();
        t_divider();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule